// File: doc/BRIEF.md
# Four-Site Parallel Test Controller

This block sits above four independent device-test engines and makes them run side by side. A single start request launches every engine in the same cycle. Each site then follows its own small state machine, so each one finishes on its own done strobe, in any order. When a site completes, the block captures that site's pass/fail verdict and the byte it last observed. With the repeat switch on, the site is relaunched at once. With the switch off, the site stops after one full pass over its vectors.

A three-bit selector picks which site is shown on the front panel. The panel has an eight-bit LED byte and a four-character code. The code reads `IC<n>P` for a passing site and `IC<n>F` for a failing site. It reads a dash pattern while the site is running and has no verdict yet. Selector values that name no site blank the panel. In the slow viewing mode the panel refreshes only on an internal enable, which a divide-by counter on the master clock produces about twice a second. In fast mode the panel refreshes every clock.

Top module: `quad_site_test_ctrl`

## Requirements
- R1: After reset, no start strobe is driven, `busy` is 0, the LED byte is 0 and the display code is four ASCII spaces (0x20202020).
- R2: A start request seen while no site is running raises all four `site_start` bits for exactly one cycle on the next clock, and `busy` goes to 1 on the same clock.
- R3: A start request while any site is running is ignored: no start strobe follows, and results already captured are kept.
- R4: Sites complete independently on their own done bit, and `busy` stays 1 until every site has completed.
- R5: With the repeat switch off, a completed site is not relaunched. While no site runs and no start is requested, `site_start` stays 0.
- R6: With the repeat switch on, a site's done bit relaunches only that site, with its own `site_start` bit on the next clock, and `busy` stays 1.
- R7: A selected site that has a passing verdict shows ASCII `I`,`C`,digit,`P` (0x49, 0x43, 0x30+site, 0x50), with the first character in bits 31:24.
- R8: A selected site that has a failing verdict shows `I`,`C`,digit,`F` (last character 0x46).
- R9: A selected site that is running with no verdict yet shows `----` (0x2D2D2D2D). An idle site with no verdict shows four spaces.
- R10: The LED byte shows the observed byte captured at the selected site's last done. An accepted start clears every captured byte to 0.
- R11: Selector codes 1 to 4 select sites 1 to 4. Codes 0 and 5 to 7 give four spaces and an LED byte of 0.
- R12: In fast mode the panel follows its inputs one clock later. In slow mode it changes only on the internal enable, which fires once every `SLOW_DIV` clocks.
- R13: A done bit from a site that is not running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| site_sel | input | 3 | Site chosen for display (1..4; other codes blank the panel) |
| fast_mode | input | 1 | 1: refresh the panel every clock; 0: refresh on the slow enable |
| loop_mode | input | 1 | 1: relaunch each site after it completes; 0: run it once |
| start_req | input | 1 | Request to launch all sites |
| site_done | input | 4 | Per-site completion strobe |
| site_pass | input | 4 | Per-site verdict, valid with done |
| site_obs | input | 32 | Per-site observed byte, site n in bits 8n-1:8n-8 |
| site_start | output | 4 | Per-site launch strobe |
| led_byte | output | 8 | Captured byte of the selected site |
| disp_code | output | 32 | Four ASCII characters, first in bits 31:24 |
| busy | output | 1 | Any site running |

## Verification
The hardest state to reach from the ports is a mixed one: some sites hold verdicts while one is still running, and the repeat switch is changed between completions. The stimulus launches all sites and completes three of them with different verdicts and bytes. It walks the selector over all eight codes while the fourth site still runs. It then turns repeat on and completes one site alone to watch that site relaunch by itself. The slow-mode rate is measured by aligning to one panel change and counting clocks until the next.

// File: rtl/qst_pkg.sv
package qst_pkg;

    localparam logic [7:0] CH_I     = 8'h49;
    localparam logic [7:0] CH_C     = 8'h43;
    localparam logic [7:0] CH_PASS  = 8'h50;
    localparam logic [7:0] CH_FAIL  = 8'h46;
    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [31:0] CODE_BLANK = 32'h2020_2020;
    localparam logic [31:0] CODE_BUSY  = 32'h2D2D_2D2D;

    function automatic logic [31:0] verdict_code(input logic [7:0] digit, input logic ok);
        return {CH_I, CH_C, digit, (ok ? CH_PASS : CH_FAIL)};
    endfunction

endpackage

// File: rtl/qst_slow_tick.sv
module qst_slow_tick #(
    parameter int unsigned DIV = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qst_site.sv
module qst_site #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              loop_mode,
    input  logic              done,
    input  logic              pass,
    input  logic [DATA_W-1:0] obs,
    output logic              start_o,
    output logic              run_o,
    output logic              valid_o,
    output logic              pass_o,
    output logic [DATA_W-1:0] obs_o
);
    typedef struct packed {
        logic              start;
        logic              run;
        logic              valid;
        logic              pass;
        logic [DATA_W-1:0] obs;
    } site_t;

    site_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (launch) begin
            st_d.start = 1'b1;
            st_d.run   = 1'b1;
            st_d.valid = 1'b0;
            st_d.pass  = 1'b0;
            st_d.obs   = '0;
        end else if (st_q.run && done) begin
            st_d.valid = 1'b1;
            st_d.pass  = pass;
            st_d.obs   = obs;
            if (loop_mode) st_d.start = 1'b1;
            else           st_d.run   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o = st_q.start;
    assign run_o   = st_q.run;
    assign valid_o = st_q.valid;
    assign pass_o  = st_q.pass;
    assign obs_o   = st_q.obs;
endmodule

// File: rtl/quad_site_test_ctrl.sv
module quad_site_test_ctrl #(
    parameter int unsigned N_SITES  = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned SLOW_DIV = 25_000_000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  site_sel,
    input  logic                        fast_mode,
    input  logic                        loop_mode,
    input  logic                        start_req,
    input  logic [N_SITES-1:0]          site_done,
    input  logic [N_SITES-1:0]          site_pass,
    input  logic [N_SITES*DATA_W-1:0]   site_obs,
    output logic [N_SITES-1:0]          site_start,
    output logic [DATA_W-1:0]           led_byte,
    output logic [31:0]                 disp_code,
    output logic                        busy
);
    import qst_pkg::*;

    typedef struct packed {
        logic [31:0]       code;
        logic [DATA_W-1:0] led;
    } view_t;

    logic [N_SITES-1:0] run_w, valid_w, pass_w;
    logic [DATA_W-1:0]  obs_w [N_SITES];
    logic               launch;
    logic               slow_tick;
    view_t              view_d, view_q;

    assign busy   = |run_w;
    assign launch = start_req && !busy;

    for (genvar g = 0; g < N_SITES; g++) begin : g_site
        qst_site #(.DATA_W(DATA_W)) u_site (
            .clk       (clk),
            .rst_n     (rst_n),
            .launch    (launch),
            .loop_mode (loop_mode),
            .done      (site_done[g]),
            .pass      (site_pass[g]),
            .obs       (site_obs[g*DATA_W +: DATA_W]),
            .start_o   (site_start[g]),
            .run_o     (run_w[g]),
            .valid_o   (valid_w[g]),
            .pass_o    (pass_w[g]),
            .obs_o     (obs_w[g])
        );
    end

    qst_slow_tick #(.DIV(SLOW_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slow_tick)
    );

    always_comb begin
        view_d = view_q;
        if (fast_mode || slow_tick) begin
            view_d.code = CODE_BLANK;
            view_d.led  = '0;
            for (int i = 0; i < N_SITES; i++) begin
                if (32'(site_sel) == i + 1) begin
                    view_d.led = obs_w[i];
                    if (valid_w[i])
                        view_d.code = verdict_code(CH_ZERO + 8'(i + 1), pass_w[i]);
                    else if (run_w[i])
                        view_d.code = CODE_BUSY;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) view_q <= '{code: CODE_BLANK, led: '0};
        else        view_q <= view_d;
    end

    assign disp_code = view_q.code;
    assign led_byte  = view_q.led;
endmodule

// File: rtl/qst_checker.sv
module qst_checker #(
    parameter int unsigned N_SITES = 4,
    parameter int unsigned DATA_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           site_sel,
    input logic                 fast_mode,
    input logic                 start_req,
    input logic [N_SITES-1:0]   site_done,
    input logic [N_SITES-1:0]   site_start,
    input logic                 busy,
    input logic                 tick,
    input logic [31:0]          disp_code,
    input logic [DATA_W-1:0]    led_byte
);
    a_r2_launch_all: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy) |=> (&site_start && busy));

    a_r3_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req && site_done == '0) |=> (site_start == '0));

    a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_req) |=> (site_start == '0));

    a_r11_blank_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_mode && (site_sel == 3'd0 || 32'(site_sel) > N_SITES))
        |=> (disp_code == 32'h2020_2020 && led_byte == '0));

    a_r12_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_mode && !tick) |=> ($stable(disp_code) && $stable(led_byte)));
endmodule

bind quad_site_test_ctrl qst_checker #(.N_SITES(N_SITES), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .site_sel   (site_sel),
    .fast_mode  (fast_mode),
    .start_req  (start_req),
    .site_done  (site_done),
    .site_start (site_start),
    .busy       (busy),
    .tick       (slow_tick),
    .disp_code  (disp_code),
    .led_byte   (led_byte)
);

// File: tb/quad_site_test_ctrl_tb.sv
module quad_site_test_ctrl_tb;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  site_sel;
    logic        fast_mode, loop_mode, start_req;
    logic [3:0]  site_done, site_pass;
    logic [31:0] site_obs;
    logic [3:0]  site_start;
    logic [7:0]  led_byte;
    logic [31:0] disp_code;
    logic        busy;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    quad_site_test_ctrl #(.N_SITES(4), .DATA_W(8), .SLOW_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .site_sel(site_sel), .fast_mode(fast_mode),
        .loop_mode(loop_mode), .start_req(start_req), .site_done(site_done),
        .site_pass(site_pass), .site_obs(site_obs), .site_start(site_start),
        .led_byte(led_byte), .disp_code(disp_code), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_done(input logic [3:0] d, input logic [3:0] p, input logic [31:0] o);
        site_done = d; site_pass = p; site_obs = o;
        @(negedge clk);
        site_done = '0;
    endtask

    // {sel, code, led}
    localparam logic [42:0] TBL [8] = '{
        {3'd0, 32'h2020_2020, 8'h00},
        {3'd1, 32'h4943_3150, 8'hA5},
        {3'd2, 32'h4943_3246, 8'h3C},
        {3'd3, 32'h4943_3350, 8'hFF},
        {3'd4, 32'h2D2D_2D2D, 8'h00},
        {3'd5, 32'h2020_2020, 8'h00},
        {3'd6, 32'h2020_2020, 8'h00},
        {3'd7, 32'h2020_2020, 8'h00}
    };

    initial begin
        rst_n = 0; site_sel = 0; fast_mode = 1; loop_mode = 0; start_req = 0;
        site_done = 0; site_pass = 0; site_obs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 start", {28'd0, site_start}, 32'h0);
        chk("R1 busy", {31'd0, busy}, 32'h0);
        chk("R1 led", {24'd0, led_byte}, 32'h0);
        chk("R1 code", disp_code, 32'h2020_2020);

        // R13: done from an idle site is ignored
        site_sel = 3'd1;
        pulse_done(4'b0001, 4'b0001, 32'h0000_00AA);
        @(negedge clk);
        chk("R13 code", disp_code, 32'h2020_2020);
        chk("R13 led", {24'd0, led_byte}, 32'h0);
        chk("R13 busy", {31'd0, busy}, 32'h0);

        // R2 launch
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        chk("R2 start", {28'd0, site_start}, 32'hF);
        chk("R2 busy", {31'd0, busy}, 32'h1);
        @(negedge clk);
        chk("R9 running code", disp_code, 32'h2D2D_2D2D);
        chk("R10 cleared led", {24'd0, led_byte}, 32'h0);
        chk("R2 single pulse", {28'd0, site_start}, 32'h0);

        // R4: three sites finish, fourth keeps running
        pulse_done(4'b0111, 4'b0101, 32'h00FF_3CA5);
        chk("R4 busy held", {31'd0, busy}, 32'h1);
        chk("R5 no relaunch", {28'd0, site_start}, 32'h0);

        // R7 R8 R9 R10 R11 table
        for (int k = 0; k < 8; k++) begin
            site_sel = TBL[k][42:40];
            @(negedge clk);
            chk($sformatf("R11/R7/R8 code sel%0d", k), disp_code, TBL[k][39:8]);
            chk($sformatf("R10 led sel%0d", k), {24'd0, led_byte}, {24'd0, TBL[k][7:0]});
        end

        // R3: start while busy is ignored
        site_sel = 3'd1;
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        chk("R3 no start", {28'd0, site_start}, 32'h0);
        @(negedge clk);
        chk("R3 code kept", disp_code, 32'h4943_3150);
        chk("R3 led kept", {24'd0, led_byte}, 32'hA5);

        // last site fails
        pulse_done(4'b1000, 4'b0000, 32'h1100_0000);
        chk("R4 busy drops", {31'd0, busy}, 32'h0);
        chk("R5 no relaunch", {28'd0, site_start}, 32'h0);
        site_sel = 3'd4;
        @(negedge clk);
        chk("R8 fail code", disp_code, 32'h4943_3446);
        chk("R10 led site4", {24'd0, led_byte}, 32'h11);

        // R6 repeat mode
        loop_mode = 1;
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        @(negedge clk);
        pulse_done(4'b0010, 4'b0010, 32'h0000_7700);
        chk("R6 own restart", {28'd0, site_start}, 32'h2);
        chk("R6 busy", {31'd0, busy}, 32'h1);
        site_sel = 3'd2;
        @(negedge clk);
        chk("R6 code", disp_code, 32'h4943_3250);
        chk("R6 led", {24'd0, led_byte}, 32'h77);
        loop_mode = 0;
        pulse_done(4'b1111, 4'b1111, 32'h5A5A_5A5A);
        chk("R5 stop after loop", {31'd0, busy}, 32'h0);
        chk("R5 no strobe", {28'd0, site_start}, 32'h0);

        // R12 slow refresh
        fast_mode = 0;
        site_sel = 3'd1;
        begin
            int waited = 0;
            while (disp_code == 32'h4943_3250 && waited < 3*DIV) begin
                @(negedge clk);
                waited++;
            end
            chk("R12 slow update seen", disp_code, 32'h4943_3150);
            site_sel = 3'd3;
            waited = 0;
            while (disp_code == 32'h4943_3150 && waited < 3*DIV) begin
                @(negedge clk);
                waited++;
            end
            chk("R12 period", waited, DIV);
            chk("R12 new code", disp_code, 32'h4943_3350);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule